// File: doc/BRIEF.md
# Two-Master Arbitrating Bus Fabric

This block joins two bus masters, a processor and a DMA engine, to three zero-wait-state slaves: a boot ROM, a read/write memory and the register bank of a serial peripheral. Each master raises a request and keeps its address, direction and write data steady until the fabric answers. The fabric grants one master at a time and works out which slave the access targets. It then runs a fixed-length strobe sequence on that slave's own bus and ends with a one-cycle completion pulse to the master, which carries the read data for reads.

The processor has an extra line that marks an access as an instruction fetch. Fetches always go to the ROM as reads. Data accesses are split by a programmable boundary address. The sequencer has four states: `ST_IDLE` (arbitrate), `ST_STROBE` (strobe on the slave bus), `ST_HOLD` (read gap before capture) and `ST_DONE` (completion pulse). Its transitions are:
- IDLE→STROBE when a request is present (LOAD);
- STROBE→DONE for a write (WR_END);
- STROBE→HOLD for a read (RD_GAP);
- HOLD→DONE, capturing read data (CAPTURE);
- DONE→IDLE unconditionally (RELEASE);
- IDLE→IDLE when no request is present.

Top module: `bus_fabric`

## Requirements
- R1: `rst` is synchronous and active high. The clock edge after it is seen leaves all strobes, grants and done pulses low, and returns the sequencer to idle. The first contested grant after reset goes to the processor.
- R2: A request present at an idle edge is granted at that edge. The grant stays high through the completion cycle and falls at the next edge. The two grants are never high together.
- R3: When both masters request at the same idle edge, the master that did not receive the previous grant wins.
- R4: Read sequence. At the grant edge the selected slave's address is driven and its read strobe rises. One edge later the strobe falls and the address returns to zero. The edge after that captures the slave's read data.
- R5: Write sequence. At the grant edge the selected slave's address and write data are driven and its write strobe rises for exactly one cycle. At the next edge all three return to zero.
- R6: A processor access with `cpu_fetch`=1 always goes to the ROM as a read. `cpu_we` is ignored for fetches.
- R7: A data access whose address is at or above `periph_base` goes to the serial peripheral. A data access below it goes to the read/write memory. The address equal to the boundary counts as peripheral.
- R8: The owning master's done output pulses for exactly one cycle. For a write it follows the strobe cycle directly. For a read it follows the capture edge and comes with the captured 16-bit data on that master's read-data output, which is otherwise zero.
- R9: At most one of the five slave strobes is high in any cycle. A slave's address and write-data outputs are zero whenever its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_base | input | 16 | Lowest data address mapped to the peripheral |
| cpu_req | input | 1 | Processor request |
| cpu_fetch | input | 1 | Processor access is an instruction fetch |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_gnt | output | 1 | Processor owns the fabric |
| cpu_done | output | 1 | Processor transfer complete |
| cpu_rdata | output | 16 | Processor read data, valid with done |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | 16 | DMA address |
| dma_wdata | input | 16 | DMA write data |
| dma_gnt | output | 1 | DMA owns the fabric |
| dma_done | output | 1 | DMA transfer complete |
| dma_rdata | output | 16 | DMA read data, valid with done |
| rom_addr | output | 16 | ROM address |
| rom_rd | output | 1 | ROM read strobe |
| rom_rdata | input | 16 | ROM read data |
| ram_addr | output | 16 | Memory address |
| ram_wdata | output | 16 | Memory write data |
| ram_rd | output | 1 | Memory read strobe |
| ram_wr | output | 1 | Memory write strobe |
| ram_rdata | input | 16 | Memory read data |
| sio_addr | output | 16 | Peripheral address |
| sio_wdata | output | 16 | Peripheral write data |
| sio_rd | output | 1 | Peripheral read strobe |
| sio_wr | output | 1 | Peripheral write strobe |
| sio_rdata | input | 16 | Peripheral read data |

## Verification
The properties assume a master keeps its request, direction, fetch flag, address and write data steady from the cycle it raises the request until its done pulse. They also assume the master drops the request during the done cycle. A slave must present read data by the third edge of the read sequence. The directed bench drives every input on the falling clock edge, lowers each request in its completion cycle, and loads each slave's read-data input with a distinct value before the transfer starts. This makes a wrong routing choice visible on the read-data outputs.

// File: rtl/bus_fabric_pkg.sv
package bus_fabric_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_HOLD   = 2'd2,
        ST_DONE   = 2'd3
    } fab_state_e;

    typedef enum logic [1:0] {
        TGT_ROM = 2'd0,
        TGT_RAM = 2'd1,
        TGT_SIO = 2'd2
    } fab_tgt_e;

    typedef enum logic {
        MST_CPU = 1'b0,
        MST_DMA = 1'b1
    } fab_mst_e;

    localparam int unsigned NUM_TGT = 3;

endpackage

// File: rtl/fabric_arbiter.sv
module fabric_arbiter
    import bus_fabric_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arb_en,
    input  logic     cpu_req,
    input  logic     dma_req,
    output logic     win_valid,
    output fab_mst_e win_mst
);

    fab_mst_e last_q;

    always_comb begin
        win_valid = cpu_req | dma_req;
        if (cpu_req && dma_req) begin
            win_mst = (last_q == MST_CPU) ? MST_DMA : MST_CPU;
        end else if (dma_req) begin
            win_mst = MST_DMA;
        end else begin
            win_mst = MST_CPU;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= MST_DMA;
        end else if (arb_en && win_valid) begin
            last_q <= win_mst;
        end
    end

endmodule

// File: rtl/fabric_decoder.sv
module fabric_decoder
    import bus_fabric_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          fetch,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    output fab_tgt_e      tgt
);

    always_comb begin
        if (fetch) begin
            tgt = TGT_ROM;
        end else if (addr >= base) begin
            tgt = TGT_SIO;
        end else begin
            tgt = TGT_RAM;
        end
    end

endmodule

// File: rtl/fabric_rd_port.sv
module fabric_rd_port #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic          rd_o,
    output logic [AW-1:0] addr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_o   <= 1'b0;
            addr_o <= '0;
        end else if (load && sel) begin
            rd_o   <= 1'b1;
            addr_o <= addr;
        end else begin
            rd_o   <= 1'b0;
            addr_o <= '0;
        end
    end

endmodule

// File: rtl/fabric_rw_port.sv
module fabric_rw_port #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          sel,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_o,
    output logic          wr_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_o    <= 1'b0;
            wr_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (load && sel) begin
            rd_o    <= ~we;
            wr_o    <= we;
            addr_o  <= addr;
            wdata_o <= we ? wdata : '0;
        end else begin
            rd_o    <= 1'b0;
            wr_o    <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
        end
    end

endmodule

// File: rtl/bus_fabric.sv
module bus_fabric
    import bus_fabric_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] periph_base,
    input  logic          cpu_req,
    input  logic          cpu_fetch,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    input  logic          dma_req,
    input  logic          dma_we,
    input  logic [AW-1:0] dma_addr,
    input  logic [DW-1:0] dma_wdata,
    output logic          dma_gnt,
    output logic          dma_done,
    output logic [DW-1:0] dma_rdata,
    output logic [AW-1:0] rom_addr,
    output logic          rom_rd,
    input  logic [DW-1:0] rom_rdata,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_rd,
    output logic          ram_wr,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] sio_addr,
    output logic [DW-1:0] sio_wdata,
    output logic          sio_rd,
    output logic          sio_wr,
    input  logic [DW-1:0] sio_rdata
);

    fab_state_e           state_q, state_d;
    fab_mst_e             win_mst, owner_q;
    fab_tgt_e             req_tgt, tgt_q;
    logic                 win_valid, load;
    logic                 req_fetch, req_we, we_q;
    logic [AW-1:0]        req_addr;
    logic [DW-1:0]        req_wdata;
    logic [NUM_TGT-1:0]   tgt_sel;
    logic                 done_q;
    logic [DW-1:0]        rdata_q;

    assign load = (state_q == ST_IDLE) && win_valid;

    fabric_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .arb_en    (state_q == ST_IDLE),
        .cpu_req   (cpu_req),
        .dma_req   (dma_req),
        .win_valid (win_valid),
        .win_mst   (win_mst)
    );

    // Fields of the winning master
    always_comb begin
        if (win_mst == MST_CPU) begin
            req_fetch = cpu_fetch;
            req_we    = cpu_we & ~cpu_fetch;
            req_addr  = cpu_addr;
            req_wdata = cpu_wdata;
        end else begin
            req_fetch = 1'b0;
            req_we    = dma_we;
            req_addr  = dma_addr;
            req_wdata = dma_wdata;
        end
    end

    fabric_decoder #(.AW(AW)) u_dec (
        .fetch (req_fetch),
        .addr  (req_addr),
        .base  (periph_base),
        .tgt   (req_tgt)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign tgt_sel[g] = (req_tgt == fab_tgt_e'(g));
    end

    fabric_rd_port #(.AW(AW)) u_rom_port (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .sel    (tgt_sel[TGT_ROM]),
        .addr   (req_addr),
        .rd_o   (rom_rd),
        .addr_o (rom_addr)
    );

    fabric_rw_port #(.AW(AW), .DW(DW)) u_ram_port (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .sel     (tgt_sel[TGT_RAM]),
        .we      (req_we),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .rd_o    (ram_rd),
        .wr_o    (ram_wr),
        .addr_o  (ram_addr),
        .wdata_o (ram_wdata)
    );

    fabric_rw_port #(.AW(AW), .DW(DW)) u_sio_port (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .sel     (tgt_sel[TGT_SIO]),
        .we      (req_we),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .rd_o    (sio_rd),
        .wr_o    (sio_wr),
        .addr_o  (sio_addr),
        .wdata_o (sio_wdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (win_valid) state_d = ST_STROBE;
            ST_STROBE: state_d = we_q ? ST_DONE : ST_HOLD;
            ST_HOLD:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // State register and transfer context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            owner_q <= MST_CPU;
            tgt_q   <= TGT_ROM;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                owner_q <= win_mst;
                tgt_q   <= req_tgt;
                we_q    <= req_we;
            end
        end
    end

    // Registered completion outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q  <= ((state_q == ST_STROBE) && we_q) || (state_q == ST_HOLD);
            rdata_q <= '0;
            if (state_q == ST_HOLD) begin
                unique case (tgt_q)
                    TGT_ROM: rdata_q <= rom_rdata;
                    TGT_RAM: rdata_q <= ram_rdata;
                    TGT_SIO: rdata_q <= sio_rdata;
                    default: rdata_q <= '0;
                endcase
            end
        end
    end

    assign cpu_gnt   = (state_q != ST_IDLE) && (owner_q == MST_CPU);
    assign dma_gnt   = (state_q != ST_IDLE) && (owner_q == MST_DMA);
    assign cpu_done  = done_q && (owner_q == MST_CPU);
    assign dma_done  = done_q && (owner_q == MST_DMA);
    assign cpu_rdata = cpu_done ? rdata_q : '0;
    assign dma_rdata = dma_done ? rdata_q : '0;

endmodule

// File: rtl/bus_fabric_chk.sv
module bus_fabric_chk (
    input logic clk,
    input logic rst,
    input logic cpu_fetch,
    input logic cpu_gnt,
    input logic cpu_done,
    input logic dma_gnt,
    input logic dma_done,
    input logic rom_rd,
    input logic ram_rd,
    input logic ram_wr,
    input logic sio_rd,
    input logic sio_wr
);

    logic any_rd, any_wr, any_done;
    assign any_rd   = rom_rd | ram_rd | sio_rd;
    assign any_wr   = ram_wr | sio_wr;
    assign any_done = cpu_done | dma_done;

    // R1
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !(any_rd || any_wr || cpu_gnt || dma_gnt || any_done));

    // R2
    p_gnt_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && dma_gnt));

    // R2
    p_done_owned_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_done |-> cpu_gnt) and (dma_done |-> dma_gnt));

    // R4
    p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        any_rd |=> !any_rd ##1 any_done);

    // R5
    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> (!any_wr && any_done));

    // R6
    p_fetch_rom_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_gnt) && cpu_fetch) |-> rom_rd);

    // R8
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        any_done |=> !any_done);

    // R9
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_rd, ram_rd, ram_wr, sio_rd, sio_wr}));

endmodule

bind bus_fabric bus_fabric_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_fetch (cpu_fetch),
    .cpu_gnt   (cpu_gnt),
    .cpu_done  (cpu_done),
    .dma_gnt   (dma_gnt),
    .dma_done  (dma_done),
    .rom_rd    (rom_rd),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .sio_rd    (sio_rd),
    .sio_wr    (sio_wr)
);

// File: tb/bus_fabric_tb.sv
module bus_fabric_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] periph_base = 16'h8000;
    logic        cpu_req = 0, cpu_fetch = 0, cpu_we = 0;
    logic [15:0] cpu_addr = 0, cpu_wdata = 0;
    logic        cpu_gnt, cpu_done;
    logic [15:0] cpu_rdata;
    logic        dma_req = 0, dma_we = 0;
    logic [15:0] dma_addr = 0, dma_wdata = 0;
    logic        dma_gnt, dma_done;
    logic [15:0] dma_rdata;
    logic [15:0] rom_addr, ram_addr, ram_wdata, sio_addr, sio_wdata;
    logic        rom_rd, ram_rd, ram_wr, sio_rd, sio_wr;
    logic [15:0] rom_rdata = 16'hA5A5, ram_rdata = 16'h1234, sio_rdata = 16'h0F0F;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    bus_fabric u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] strobes();
        return {rom_rd, ram_rd, ram_wr, sio_rd, sio_wr};
    endfunction

    // tgt: 0 ROM, 1 RAM, 2 SIO
    task automatic xfer(input bit is_dma, input bit fetch, input bit we,
                        input logic [15:0] addr, input logic [15:0] wdata,
                        input int tgt, input string tag);
        logic [4:0]  exp_strb;
        logic [15:0] exp_rd;
        bit          eff_we;
        eff_we = we && !fetch;
        case (tgt)
            0:       begin exp_strb = 5'b10000; exp_rd = rom_rdata; end
            1:       begin exp_strb = eff_we ? 5'b00100 : 5'b01000; exp_rd = ram_rdata; end
            default: begin exp_strb = eff_we ? 5'b00001 : 5'b00010; exp_rd = sio_rdata; end
        endcase
        @(negedge clk);
        if (is_dma) begin
            dma_req = 1; dma_we = we; dma_addr = addr; dma_wdata = wdata;
        end else begin
            cpu_req = 1; cpu_fetch = fetch; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        end
        @(negedge clk);
        chk({tag, " R2 grant"}, {cpu_gnt, dma_gnt}, is_dma ? 2'b01 : 2'b10);
        chk({tag, " R9 strobe select"}, strobes(), exp_strb);
        case (tgt)
            0: chk({tag, " R4 rom addr"}, rom_addr, addr);
            1: chk({tag, " R7 ram addr"}, ram_addr, addr);
            default: chk({tag, " R7 sio addr"}, sio_addr, addr);
        endcase
        if (eff_we)
            chk({tag, " R5 wdata"}, (tgt == 1) ? ram_wdata : sio_wdata, wdata);
        @(negedge clk);
        chk({tag, " R9 strobes released"}, strobes(), 5'b0);
        chk({tag, " R9 addr released"}, {rom_addr, ram_addr, sio_addr, ram_wdata, sio_wdata}, 0);
        if (eff_we) begin
            chk({tag, " R8 write done"}, {cpu_done, dma_done}, is_dma ? 2'b01 : 2'b10);
        end else begin
            chk({tag, " R4 no early done"}, {cpu_done, dma_done}, 2'b00);
            @(negedge clk);
            chk({tag, " R8 read done"}, {cpu_done, dma_done}, is_dma ? 2'b01 : 2'b10);
            chk({tag, " R4 read data"}, is_dma ? dma_rdata : cpu_rdata, exp_rd);
        end
        cpu_req = 0; dma_req = 0;
        @(negedge clk);
        chk({tag, " R8 done single cycle"}, {cpu_done, dma_done}, 2'b00);
        chk({tag, " R2 grant released"}, {cpu_gnt, dma_gnt}, 2'b00);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {strobes(), cpu_gnt, dma_gnt, cpu_done, dma_done}, 0);
        rst = 0;
    endtask

    task automatic t_fetch();
        rom_rdata = 16'hC0DE;
        xfer(0, 1, 0, 16'h0040, 16'h0, 0, "fetch");
        // R6: we ignored on fetch
        rom_rdata = 16'hBEEF;
        xfer(0, 1, 1, 16'h9000, 16'h5555, 0, "R6 fetch with we");
        chk("R6 ram untouched", {ram_wr, sio_wr}, 2'b00);
    endtask

    task automatic t_decode();
        ram_rdata = 16'h2468;
        xfer(0, 0, 1, 16'h0100, 16'hABCD, 1, "R7 cpu ram write");
        xfer(0, 0, 0, 16'h7FFF, 16'h0, 1, "R7 below base");
        sio_rdata = 16'h1357;
        xfer(0, 0, 0, 16'h8000, 16'h0, 2, "R7 at base");
        xfer(1, 0, 1, 16'hFFFF, 16'h7E7E, 2, "R7 dma sio write");
        periph_base = 16'h0200;
        xfer(1, 0, 0, 16'h0200, 16'h0, 2, "R7 moved base");
        ram_rdata = 16'h9ABC;
        xfer(1, 0, 0, 16'h01FF, 16'h0, 1, "R7 dma ram read");
        periph_base = 16'h8000;
    endtask

    task automatic t_arb();
        // both request; CPU was last granted? depends on history -> force known state
        xfer(1, 0, 1, 16'h0010, 16'h0001, 1, "arb prep dma");
        @(negedge clk);
        cpu_req = 1; cpu_fetch = 0; cpu_we = 0; cpu_addr = 16'h0020;
        dma_req = 1; dma_we = 1; dma_addr = 16'h9000; dma_wdata = 16'h4242;
        @(negedge clk);
        chk("R3 cpu wins after dma", {cpu_gnt, dma_gnt}, 2'b10);
        @(negedge clk);
        @(negedge clk);
        chk("R8 cpu done in contest", cpu_done, 1'b1);
        cpu_req = 0;
        @(negedge clk);
        chk("R2 idle gap", {cpu_gnt, dma_gnt}, 2'b00);
        @(negedge clk);
        chk("R3 dma served next", {dma_gnt, sio_wr}, 2'b11);
        chk("R5 dma wdata", sio_wdata, 16'h4242);
        @(negedge clk);
        chk("R8 dma write done", dma_done, 1'b1);
        dma_req = 0;
        @(negedge clk);
        xfer(0, 0, 0, 16'h0030, 16'h0, 1, "arb prep cpu");
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 16'h0040;
        dma_req = 1; dma_we = 0; dma_addr = 16'h0050;
        @(negedge clk);
        chk("R3 dma wins after cpu", {cpu_gnt, dma_gnt}, 2'b01);
        chk("R4 dma ram read strobe", {ram_rd, ram_addr}, {1'b1, 16'h0050});
        @(negedge clk);
        @(negedge clk);
        dma_req = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 cpu served next", cpu_gnt, 1'b1);
        @(negedge clk);
        @(negedge clk);
        cpu_req = 0;
        @(negedge clk);
    endtask

    task automatic t_first_contest();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        cpu_req = 1; cpu_we = 0; cpu_fetch = 1; cpu_addr = 16'h0004;
        dma_req = 1; dma_we = 0; dma_addr = 16'h0008;
        @(negedge clk);
        chk("R1 first contest to cpu", {cpu_gnt, dma_gnt}, 2'b10);
        chk("R6 fetch strobes rom", strobes(), 5'b10000);
        // reset mid-transfer returns to idle
        rst = 1; cpu_req = 0; dma_req = 0; cpu_fetch = 0;
        @(negedge clk);
        chk("R1 reset mid transfer", {strobes(), cpu_gnt, dma_gnt, cpu_done, dma_done}, 0);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_first_contest();
        t_fetch();
        t_decode();
        t_arb();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule